// File: doc/BRIEF.md
# Multiplexed Bank Address Bus Interface

This block sits between a processor core and its external memory bus. The core supplies a 24-bit address, one byte of write data and a read/write flag. The block splits the address into two parts. The low 16 bits go out on dedicated address pins. The upper 8 bits, the bank byte, go out on the shared 8-bit data pins during the first half of each bus cycle. In the second half the data pins carry the write byte on writes. On reads they are released so that memory can drive them, and the byte they carry is captured at the end of that half.

Tri-state drivers are modelled as value/enable pairs. A bus-enable input gates every driver enable with no clock involved. This lets another bus master take over the pins at any moment. The bus-cycle sequence continues internally while the drivers are off.

The half-cycle is given by the phase input `phi`. It is sampled on `clk`, which runs several times faster than the bus. A bus cycle begins at the first `clk` edge that sees `phi` low after it was high. The core request is latched on that edge and held until the next cycle begins.

Top module: `bank_mux_bus`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, `pin_addr` is 0, `pin_rw` is 1 (read), `pin_data_out` is 0, `pin_data_oe` is 0 and `rd_data` is 0.
- R2: A cycle starts on the first `clk` edge where `phi` is 0 (address half) after it was 1 (data half). From that edge until the next start, `pin_addr` shows the latched `core_addr[15:0]` and does not change.
- R3: During the address half, `pin_data_out` equals the latched bank byte `core_addr[23:16]`, and `pin_data_oe` is 1 whenever `bus_en` is 1.
- R4: During the data half of a write cycle, `pin_data_out` equals the latched `core_wdata`, and `pin_data_oe` is 1 whenever `bus_en` is 1.
- R5: During the data half of a read cycle, `pin_data_oe` is 0.
- R6: `pin_rw` is 1 for a read (`core_read`=1) and 0 for a write, for the whole cycle.
- R7: With `bus_en` 0, `pin_addr_oe`, `pin_rw_oe` and `pin_data_oe` are all 0. The change happens at once, without a clock edge.
- R8: With `bus_en` 1, `pin_addr_oe` and `pin_rw_oe` are 1.
- R9: On the edge that ends the data half of a read cycle, `rd_data` loads `pin_data_in`. After a write cycle, and at all other times, `rd_data` is unchanged.
- R10: Changes on `core_addr`, `core_wdata` and `core_read` during a cycle have no effect on the pins until the next cycle start.
- R11: With `bus_en` 0, cycles still start, requests are still latched and read data is still captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| phi | input | 1 | Bus phase: 0 address half, 1 data half |
| bus_en | input | 1 | Asynchronous driver enable |
| core_addr | input | 24 | Core address; bits 23:16 are the bank |
| core_wdata | input | 8 | Core write byte |
| core_read | input | 1 | 1 read, 0 write |
| pin_addr | output | 16 | Low address pin values |
| pin_addr_oe | output | 1 | Address driver enable |
| pin_data_out | output | 8 | Data pin drive value (bank or write data) |
| pin_data_oe | output | 1 | Data driver enable |
| pin_data_in | input | 8 | Data pin value seen from the bus |
| pin_rw | output | 1 | Read/write pin value |
| pin_rw_oe | output | 1 | Read/write driver enable |
| rd_data | output | 8 | Captured read byte |

## Verification
Four rules are checked on every clock by the assertions:
- the enables follow `bus_en` and the phase;
- the address and read/write pins stay stable inside a cycle;
- the data driver is released in the data half of a read;
- `rd_data` changes only on the edge that ends a read.

Other behaviours need the bench's scenarios:
- the values on the pins, meaning the bank byte and the write byte against what the core supplied;
- the captured read byte;
- core inputs being ignored in mid-cycle;
- the enables dropping between clock edges when `bus_en` falls asynchronously.

// File: rtl/bank_mux_pkg.sv
package bank_mux_pkg;

    localparam int LOW_ADDR_W  = 16;
    localparam int BYTE_W      = 8;
    localparam int FULL_ADDR_W = LOW_ADDR_W + BYTE_W;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } bus_phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0]     bank;
        logic [LOW_ADDR_W-1:0] low;
        logic [BYTE_W-1:0]     wdata;
        logic                  is_read;
    } bus_req_t;

    localparam bus_req_t REQ_IDLE = '{bank: '0, low: '0, wdata: '0, is_read: 1'b1};

    function automatic bus_req_t make_req(
        input logic [FULL_ADDR_W-1:0] addr,
        input logic [BYTE_W-1:0]      wdata,
        input logic                   is_read
    );
        bus_req_t r;
        r.bank    = addr[FULL_ADDR_W-1:LOW_ADDR_W];
        r.low     = addr[LOW_ADDR_W-1:0];
        r.wdata   = wdata;
        r.is_read = is_read;
        return r;
    endfunction

endpackage

// File: rtl/bmx_phase_track.sv
module bmx_phase_track
    import bank_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       phi,
    output bus_phase_e phase_q,
    output logic       cycle_edge
);
    // A new cycle begins when the address half follows a data half.
    assign cycle_edge = (phase_q == PH_DATA) && (phi == 1'b0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_DATA;
        end else begin
            phase_q <= bus_phase_e'(phi);
        end
    end
endmodule

// File: rtl/bmx_req_latch.sv
module bmx_req_latch
    import bank_mux_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  bus_req_t req_in,
    output bus_req_t req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= REQ_IDLE;
        end else if (load) begin
            req_q <= req_in;
        end
    end
endmodule

// File: rtl/bmx_pin_drive.sv
module bmx_pin_drive
    import bank_mux_pkg::*;
(
    input  bus_phase_e            phase_q,
    input  bus_req_t              req_q,
    input  logic                  bus_en,
    output logic [LOW_ADDR_W-1:0] pin_addr,
    output logic                  pin_addr_oe,
    output logic [BYTE_W-1:0]     pin_data_out,
    output logic                  pin_data_oe,
    output logic                  pin_rw,
    output logic                  pin_rw_oe
);
    logic in_addr_half;
    assign in_addr_half = (phase_q == PH_ADDR);

    // Per-bit selection between the bank byte and the write byte.
    for (genvar b = 0; b < BYTE_W; b++) begin : g_dmux
        assign pin_data_out[b] = in_addr_half ? req_q.bank[b] : req_q.wdata[b];
    end

    assign pin_addr     = req_q.low;
    assign pin_rw       = req_q.is_read;
    assign pin_addr_oe  = bus_en;
    assign pin_rw_oe    = bus_en;
    assign pin_data_oe  = bus_en & (in_addr_half | ~req_q.is_read);
endmodule

// File: rtl/bmx_rd_capture.sv
module bmx_rd_capture
    import bank_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cycle_edge,
    input  logic              is_read,
    input  logic [BYTE_W-1:0] pin_data_in,
    output logic [BYTE_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (cycle_edge && is_read) begin
            rd_data <= pin_data_in;
        end
    end
endmodule

// File: rtl/bank_mux_bus.sv
module bank_mux_bus
    import bank_mux_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   phi,
    input  logic                   bus_en,
    input  logic [FULL_ADDR_W-1:0] core_addr,
    input  logic [BYTE_W-1:0]      core_wdata,
    input  logic                   core_read,
    output logic [LOW_ADDR_W-1:0]  pin_addr,
    output logic                   pin_addr_oe,
    output logic [BYTE_W-1:0]      pin_data_out,
    output logic                   pin_data_oe,
    input  logic [BYTE_W-1:0]      pin_data_in,
    output logic                   pin_rw,
    output logic                   pin_rw_oe,
    output logic [BYTE_W-1:0]      rd_data
);
    bus_phase_e phase_q;
    logic       cycle_edge;
    bus_req_t   req_q;
    bus_req_t   req_next;

    assign req_next = make_req(core_addr, core_wdata, core_read);

    bmx_phase_track u_phase (
        .clk        (clk),
        .rst        (rst),
        .phi        (phi),
        .phase_q    (phase_q),
        .cycle_edge (cycle_edge)
    );

    bmx_req_latch u_req (
        .clk    (clk),
        .rst    (rst),
        .load   (cycle_edge),
        .req_in (req_next),
        .req_q  (req_q)
    );

    bmx_pin_drive u_drive (
        .phase_q      (phase_q),
        .req_q        (req_q),
        .bus_en       (bus_en),
        .pin_addr     (pin_addr),
        .pin_addr_oe  (pin_addr_oe),
        .pin_data_out (pin_data_out),
        .pin_data_oe  (pin_data_oe),
        .pin_rw       (pin_rw),
        .pin_rw_oe    (pin_rw_oe)
    );

    bmx_rd_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .cycle_edge  (cycle_edge),
        .is_read     (req_q.is_read),
        .pin_data_in (pin_data_in),
        .rd_data     (rd_data)
    );
endmodule

// File: rtl/bank_mux_bus_chk.sv
module bank_mux_bus_chk
    import bank_mux_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input bus_phase_e        phase_q,
    input logic              cycle_edge,
    input logic [15:0]       pin_addr,
    input logic              pin_addr_oe,
    input logic              pin_data_oe,
    input logic              pin_rw,
    input logic              pin_rw_oe,
    input logic [BYTE_W-1:0] rd_data
);
    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cycle_edge |=> $stable(pin_addr));

    // R6
    rw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cycle_edge |=> $stable(pin_rw));

    // R3
    bank_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && phase_q == PH_ADDR) |-> pin_data_oe);

    // R4
    write_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && phase_q == PH_DATA && !pin_rw) |-> pin_data_oe);

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && pin_rw) |-> !pin_data_oe);

    // R7
    bus_off_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_en |-> (!pin_addr_oe && !pin_rw_oe && !pin_data_oe));

    // R8
    bus_on_chk: assert property (@(posedge clk) disable iff (rst)
        bus_en |-> (pin_addr_oe && pin_rw_oe));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cycle_edge && pin_rw) |=> $stable(rd_data));
endmodule

bind bank_mux_bus bank_mux_bus_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_en      (bus_en),
    .phase_q     (phase_q),
    .cycle_edge  (cycle_edge),
    .pin_addr    (pin_addr),
    .pin_addr_oe (pin_addr_oe),
    .pin_data_oe (pin_data_oe),
    .pin_rw      (pin_rw),
    .pin_rw_oe   (pin_rw_oe),
    .rd_data     (rd_data)
);

// File: tb/bank_mux_bus_test.sv
`timescale 1ns/1ps
module bank_mux_bus_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi = 1'b1;
    logic        bus_en = 1'b1;
    logic [23:0] core_addr = '0;
    logic [7:0]  core_wdata = '0;
    logic        core_read = 1'b1;
    logic [7:0]  pin_data_in = '0;
    logic [15:0] pin_addr;
    logic        pin_addr_oe, pin_data_oe, pin_rw, pin_rw_oe;
    logic [7:0]  pin_data_out, rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_rd = '0;

    always #10 clk = ~clk;

    bank_mux_bus uut (
        .clk(clk), .rst(rst), .phi(phi), .bus_en(bus_en),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_read(core_read),
        .pin_addr(pin_addr), .pin_addr_oe(pin_addr_oe),
        .pin_data_out(pin_data_out), .pin_data_oe(pin_data_oe),
        .pin_data_in(pin_data_in), .pin_rw(pin_rw), .pin_rw_oe(pin_rw_oe),
        .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pin_addr == 16'h0, "R1 addr", {16'h0, pin_addr}, 0);
        check(pin_rw == 1'b1, "R1 rw", {31'h0, pin_rw}, 1);
        check(pin_data_out == 8'h0, "R1 data_out", {24'h0, pin_data_out}, 0);
        check(pin_data_oe == 1'b0, "R1 data_oe", {31'h0, pin_data_oe}, 0);
        check(rd_data == 8'h0, "R1 rd_data", {24'h0, rd_data}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(pin_addr == 16'h0 && pin_rw && rd_data == 8'h0, "R1 post-reset",
              {pin_addr, 7'h0, pin_rw, rd_data}, 32'h0000_0100);
    endtask

    // One full bus cycle: address half then data half, one clk each plus settle.
    task automatic bus_cycle(input logic [23:0] a, input logic [7:0] wd, input bit rd,
                             input logic [7:0] din, input bit en);
        @(negedge clk);
        core_addr = a; core_wdata = wd; core_read = rd; bus_en = en; phi = 1'b0;
        @(negedge clk);
        check(pin_addr == a[15:0], "R2 low address", {16'h0, pin_addr}, {16'h0, a[15:0]});
        check(pin_data_out == a[23:16], "R3 bank byte", {24'h0, pin_data_out}, {24'h0, a[23:16]});
        check(pin_data_oe == en, "R3 bank enable", {31'h0, pin_data_oe}, {31'h0, en});
        check(pin_rw == rd, "R6 rw first half", {31'h0, pin_rw}, {31'h0, rd});
        check(rd_data == exp_rd, "R9 rd_data", {24'h0, rd_data}, {24'h0, exp_rd});
        check(pin_addr_oe == en && pin_rw_oe == en, en ? "R8 enables" : "R7 enables",
              {30'h0, pin_addr_oe, pin_rw_oe}, {30'h0, en, en});
        phi = 1'b1; pin_data_in = din;
        @(negedge clk);
        check(pin_rw == rd, "R6 rw second half", {31'h0, pin_rw}, {31'h0, rd});
        check(pin_addr == a[15:0], "R2 address held", {16'h0, pin_addr}, {16'h0, a[15:0]});
        if (rd) begin
            check(pin_data_oe == 1'b0, "R5 read release", {31'h0, pin_data_oe}, 0);
        end else begin
            check(pin_data_out == wd, "R4 write byte", {24'h0, pin_data_out}, {24'h0, wd});
            check(pin_data_oe == en, "R4 write enable", {31'h0, pin_data_oe}, {31'h0, en});
        end
        if (rd) exp_rd = din;
    endtask

    task automatic test_rw_mix();
        bus_cycle(24'h12_3456, 8'hA5, 1'b0, 8'h00, 1'b1);
        bus_cycle(24'hFE_0001, 8'h00, 1'b1, 8'h3C, 1'b1);
        bus_cycle(24'h00_FFFF, 8'h5A, 1'b0, 8'hEE, 1'b1);
        bus_cycle(24'h80_8000, 8'hFF, 1'b1, 8'hC3, 1'b1);
        bus_cycle(24'hFF_FFFF, 8'h01, 1'b0, 8'h77, 1'b1);
    endtask

    task automatic test_ignore_midcycle();
        @(negedge clk);
        core_addr = 24'h55_AAAA; core_wdata = 8'h99; core_read = 1'b0; phi = 1'b0;
        @(negedge clk);
        core_addr = 24'h11_2222; core_wdata = 8'h33; core_read = 1'b1;
        @(negedge clk);
        check(pin_addr == 16'hAAAA && pin_data_out == 8'h55 && !pin_rw, "R10 address half",
              {pin_addr, pin_data_out, 7'h0, pin_rw}, 32'hAAAA_5500);
        phi = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(pin_data_out == 8'h99 && !pin_rw, "R10 data half",
              {23'h0, pin_rw, pin_data_out}, 32'h99);
    endtask

    task automatic test_async_enable();
        @(negedge clk);
        core_addr = 24'h3C_1234; core_wdata = 8'h42; core_read = 1'b0; phi = 1'b0;
        @(negedge clk);
        #3 bus_en = 1'b0;
        #1 check(!pin_addr_oe && !pin_rw_oe && !pin_data_oe, "R7 async off",
                 {29'h0, pin_addr_oe, pin_rw_oe, pin_data_oe}, 0);
        #1 bus_en = 1'b1;
        #1 check(pin_addr_oe && pin_rw_oe && pin_data_oe, "R8 async on",
                 {29'h0, pin_addr_oe, pin_rw_oe, pin_data_oe}, 7);
        phi = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_disabled_cycles();
        bus_cycle(24'h0A_0B0C, 8'h00, 1'b1, 8'h6D, 1'b0);
        bus_cycle(24'h0D_0E0F, 8'h44, 1'b0, 8'h00, 1'b0);
        // R11: read done while disabled is captured, new address latched.
        check(rd_data == 8'h6D, "R11 capture while disabled", {24'h0, rd_data}, 32'h6D);
        check(pin_addr == 16'h0E0F, "R11 latch while disabled", {16'h0, pin_addr}, 32'h0E0F);
        bus_cycle(24'h01_0203, 8'h00, 1'b1, 8'h81, 1'b1);
        bus_cycle(24'h04_0506, 8'h00, 1'b0, 8'h00, 1'b1);
    endtask

    initial begin
        fork
            begin
                test_reset();
                test_rw_mix();
                test_ignore_midcycle();
                test_async_enable();
                test_disabled_cycles();
            end
            begin
                #(200000 * 20);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule